// File: doc/BRIEF.md
# Four-Activate Sliding Window Limiter

This block caps how densely a DRAM command scheduler may issue row activates. It watches a strobe that marks each activate the scheduler tries to issue, and returns a permit flag telling the scheduler whether an activate is legal in the current cycle. The rule is a true rolling one: within any run of `W` consecutive controller cycles, no more than four activates may be accepted, where `W` is a window length supplied on an input port.

Internally, four lifetime counters each track one recent activate. An accepted activate loads a counter that has run down, and the permit flag is high while at least one counter is free. A window length of zero turns the limit off: the permit stays high and nothing is recorded. The permit is derived combinationally from the counters, so the scheduler can issue in the very cycle the oldest activate leaves the window.

Top module: `fawl_limiter`

## Requirements
- R1: During and right after synchronous reset all four lifetime slots are free, `act_ok_o` is 1, and four activates in back-to-back cycles are all accepted.
- R2: With `win_len_i` = W > 0, `act_ok_o` in cycle t is 0 exactly when four accepted activates have an acceptance cycle a with a + W_a > t, where W_a is the window value in cycle a; an accepted activate is one with `act_issue_i` = 1 and `act_ok_o` = 1 in the same cycle.
- R3: An activate accepted in cycle a stops counting in cycle a + W, so a fifth activate is permitted in that cycle without a wait cycle.
- R4: While `win_len_i` is 0, `act_ok_o` is 1 in every cycle and strobes on `act_issue_i` are not recorded; after a later change to a non-zero window, they do not cause blocking.
- R5: A strobe on `act_issue_i` in a cycle where `act_ok_o` is 0 is ignored and does not extend any blocking.
- R6: Changing `win_len_i` affects only activates accepted afterwards; slots already running keep the lifetime set at their acceptance.
- R7: With W = 1, `act_ok_o` stays 1 even when an activate is issued every cycle.
- R8: When accepted activates are spaced s cycles apart with 4*s >= W, the limiter never blocks.
- R9: The largest window value, 2^WIN_W - 1, gives each slot that full lifetime with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_i | input | 1 | Synchronous active-high reset |
| win_len_i | input | WIN_W | Window length in controller cycles; 0 disables the limit |
| act_issue_i | input | 1 | Activate strobe from the scheduler |
| act_ok_o | output | 1 | High when an activate may issue this cycle |

## Verification
The bench builds the limiter with `WIN_W` = 6, so the widest window is 63 cycles and the full-lifetime corner of R9 fits in a short run while every counter bit still toggles. Window values are drawn from 0, 1, the spacing boundary of R8, mid-range values and the maximum, and are changed while slots are still running so that slots with different lifetimes coexist.

// File: rtl/fawl_pkg.sv
package fawl_pkg;

    // number of activates tolerated inside one window
    localparam int unsigned DEF_SLOTS = 4;
    // default width of the window length input
    localparam int unsigned DEF_WIN_W = 16;

    // gate state reported to the scheduler
    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_e;

    // per-cycle decision of the limiter
    typedef struct packed {
        logic  limit_off;
        logic  any_free;
        logic  accept;
        gate_e gate;
    } decide_t;

    function automatic decide_t make_decision(input logic off, input logic free,
                                              input logic issue);
        decide_t d;
        d.limit_off = off;
        d.any_free  = free;
        d.gate      = (off || free) ? GATE_OPEN : GATE_SHUT;
        d.accept    = issue && !off && free;
        return d;
    endfunction

endpackage

// File: rtl/fawl_slot.sv
module fawl_slot #(
    parameter int unsigned WIN_W = fawl_pkg::DEF_WIN_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [WIN_W-1:0] life_i,
    output logic             idle_o
);

    logic [WIN_W-1:0] life_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            life_q <= '0;
        end else if (load_i) begin
            life_q <= life_i;
        end else if (life_q != '0) begin
            life_q <= life_q - 1'b1;
        end
    end

    assign idle_o = (life_q == '0);

endmodule

// File: rtl/fawl_pick.sv
module fawl_pick #(
    parameter int unsigned SLOTS = fawl_pkg::DEF_SLOTS
) (
    input  logic [SLOTS-1:0] req_i,
    output logic [SLOTS-1:0] grant_o
);

    logic [SLOTS:0] taken;

    assign taken[0] = 1'b0;

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_chain
            assign grant_o[k]  = req_i[k] & ~taken[k];
            assign taken[k+1]  = taken[k] | req_i[k];
        end
    endgenerate

endmodule

// File: rtl/fawl_limiter.sv
module fawl_limiter
    import fawl_pkg::*;
#(
    parameter int unsigned WIN_W = DEF_WIN_W,
    parameter int unsigned SLOTS = DEF_SLOTS
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIN_W-1:0] win_len_i,
    input  logic             act_issue_i,
    output logic             act_ok_o
);

    logic [SLOTS-1:0] slot_idle;
    logic [SLOTS-1:0] slot_load;
    logic [SLOTS-1:0] pick_req;
    logic [WIN_W-1:0] life_val;
    decide_t          dec;

    // a slot loaded in cycle a must read zero in cycle a + W
    assign life_val = win_len_i - 1'b1;

    assign dec      = make_decision(win_len_i == '0, |slot_idle, act_issue_i);
    assign act_ok_o = (dec.gate == GATE_OPEN);
    assign pick_req = dec.accept ? slot_idle : '0;

    fawl_pick #(.SLOTS(SLOTS)) u_pick (
        .req_i   (pick_req),
        .grant_o (slot_load)
    );

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            fawl_slot #(.WIN_W(WIN_W)) u_slot (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .load_i (slot_load[k]),
                .life_i (life_val),
                .idle_o (slot_idle[k])
            );
        end
    endgenerate

endmodule

// File: rtl/fawl_limiter_chk.sv
module fawl_limiter_chk #(
    parameter int unsigned WIN_W = fawl_pkg::DEF_WIN_W,
    parameter int unsigned SLOTS = fawl_pkg::DEF_SLOTS
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [WIN_W-1:0] win_len_i,
    input logic             act_issue_i,
    input logic             act_ok_o,
    input logic [SLOTS-1:0] slot_idle,
    input logic [SLOTS-1:0] slot_load
);

    AST_RESET_ALL_FREE: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (&slot_idle && act_ok_o)); // R1

    AST_SINGLE_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(slot_load)); // R2

    AST_LOAD_FREE_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
        (slot_load & ~slot_idle) == '0); // R2

    AST_ACCEPT_RECORDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_issue_i && act_ok_o && win_len_i != '0) |-> $onehot(slot_load)); // R2

    AST_BLOCKED_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (!act_ok_o) |-> (slot_load == '0)); // R5

    AST_OFF_NO_RECORD: assert property (@(posedge clk_i) disable iff (rst_i)
        (win_len_i == '0) |-> (slot_load == '0)); // R4

endmodule

bind fawl_limiter fawl_limiter_chk #(.WIN_W(WIN_W), .SLOTS(SLOTS)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .win_len_i   (win_len_i),
    .act_issue_i (act_issue_i),
    .act_ok_o    (act_ok_o),
    .slot_idle   (slot_idle),
    .slot_load   (slot_load)
);

// File: tb/fawl_limiter_bench.sv
module fawl_limiter_bench;

    localparam int unsigned WIN_W = 6;
    localparam int unsigned WMAX  = (1 << WIN_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [WIN_W-1:0] win = '0;
    logic             issue = 1'b0;
    logic             ok;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int exp_q[$];
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fawl_limiter #(.WIN_W(WIN_W), .SLOTS(4)) u_fawl_limiter (
        .clk_i       (clk),
        .rst_i       (rst),
        .win_len_i   (win),
        .act_issue_i (issue),
        .act_ok_o    (ok)
    );

    function automatic int live_count(int now);
        int c = 0;
        foreach (exp_q[i]) if (exp_q[i] > now) c++;
        return c;
    endfunction

    function automatic bit model_ok(int w, int now);
        return (w == 0) || (live_count(now) < 4);
    endfunction

    task automatic check(input string tag, input logic act, input logic expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s cycle %0d: act_ok=%0b expected %0b", tag, cyc, act, expv);
        end
    endtask

    // one controller cycle: drive, check permit, update model
    task automatic step(input bit iss, input int w, input string tag);
        bit e;
        @(negedge clk);
        win   = w[WIN_W-1:0];
        issue = iss;
        #1;
        e = model_ok(w, cyc);
        check(tag, ok, e);
        if (iss && e && w != 0) exp_q.push_back(cyc + w);
        @(posedge clk);
        cyc++;
        for (int i = exp_q.size() - 1; i >= 0; i--)
            if (exp_q[i] <= cyc) exp_q.delete(i);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: reset state
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 check("R1 in reset", ok, 1'b1);
        rst = 1'b0;
        cyc = 0;
        exp_q.delete();

        // R1 and R2: four back-to-back accepted, fifth blocked
        for (int i = 0; i < 4; i++) step(1, 10, "R1");
        step(1, 10, "R2");
        // R5 and R3: keep hammering while blocked; opens exactly at cycle 10
        for (int i = 0; i < 6; i++) step(1, 10, "R5/R3");
        for (int i = 0; i < 12; i++) step(0, 10, "R2 drain");

        // R4: disabled window ignores strobes, then enabling must not block
        for (int i = 0; i < 10; i++) step(1, 0, "R4");
        step(0, 8, "R4 after enable");
        for (int i = 0; i < 4; i++) step(1, 8, "R4 fresh");
        step(1, 8, "R2 fifth");
        for (int i = 0; i < 10; i++) step(0, 8, "R2 drain");

        // R7: window of one never blocks
        for (int i = 0; i < 20; i++) step(1, 1, "R7");

        // R8: spacing 3 against window 12
        for (int i = 0; i < 20; i++) begin
            step(1, 12, "R8");
            step(0, 12, "R8");
            step(0, 12, "R8");
        end
        for (int i = 0; i < 12; i++) step(0, 12, "R8 drain");

        // R9: full-size window
        for (int i = 0; i < 4; i++) step(1, WMAX, "R9");
        for (int i = 0; i < WMAX - 4; i++) step(i[0], WMAX, "R9 hold");
        step(1, WMAX, "R9 reopen");
        for (int i = 0; i < WMAX + 2; i++) step(0, WMAX, "R9 drain");

        // R6: window change while slots run
        for (int i = 0; i < 3; i++) step(1, 30, "R6");
        step(1, 5, "R6");
        for (int i = 0; i < 30; i++) step(1, 5, "R6 mixed");

        // random phases
        for (int p = 0; p < 20; p++) begin
            int w;
            int sel = $urandom_range(0, 5);
            case (sel)
                0: w = 0;
                1: w = 1;
                2: w = 4;
                3: w = WMAX;
                default: w = $urandom_range(2, 24);
            endcase
            for (int i = 0; i < 150; i++)
                step($urandom_range(0, 99) < 60, w, "R2 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule